// File: doc/BRIEF.md
# Clock-Sampled Phase-Frequency Detector with Antibacklash Stretch

This block compares rising edges of a divided reference signal and a divided feedback signal. It produces pump-up and pump-down commands for a charge pump. All logic runs on a fast sampling clock. A reference rising edge raises the up command, and a feedback rising edge raises the down command. Whichever input rises first therefore asserts its command first, and the commands carry both phase error and frequency error.

When both commands are high, they stay high together for a programmable number of sampling cycles and then drop in the same cycle. This stretch keeps the response free of a dead zone near zero phase error.

A mode field replaces normal tracking with one of three other behaviours:
- high impedance, used for holdover, which deasserts an output enable;
- a steady pump-up command, for test;
- a steady pump-down command, for test.

A 3-bit current-step code is registered and handed on to the pump unchanged.

Top module: `pfd_abl_top`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) drives `up_o`, `dn_o`, `oe_o` and `icode_o` to 0 after that edge. The block leaves reset in high-impedance mode.
- R2: In tracking mode (`mode_i` = 1), a rising edge on `ref_i` raises `up_o`, and a rising edge on `fb_i` raises `dn_o`. A rising edge is a high sample at a clock edge that follows a low sample. The output is high after the clock edge that samples the rise, and it stays high until it is cleared.
- R3: Once `up_o` and `dn_o` are both high, both stay high for exactly `abl_sel_i`+1 sampling cycles (1 to 4 cycles for codes 0 to 3). They then fall in the same cycle.
- R4: A rising edge on an input whose output is already high is ignored. This holds while waiting for the other input and during the antibacklash overlap. The ignored edge leaves no pending pulse.
- R5: Mode 0 (high impedance) drives `oe_o` low and holds `up_o` and `dn_o` low. Modes 1, 2 and 3 drive `oe_o` high.
- R6: Mode 2 holds `up_o` high and `dn_o` low. Mode 3 holds `dn_o` high and `up_o` low.
- R7: A new `mode_i` value takes effect after the next clock edge. At that edge both internal edge latches are cleared, so an edge caught before the change never produces a pulse after the block returns to tracking.
- R8: `icode_o` equals the `icode_i` value sampled at the previous clock edge.
- R9: Input edges that arrive in modes 0, 2 or 3 are not stored. After the return to tracking, both outputs are low until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Divided reference pulse |
| fb_i | input | 1 | Divided feedback pulse |
| abl_sel_i | input | 2 | Antibacklash stretch code (cycles = code + 1) |
| mode_i | input | 2 | Pump mode: 0 high-Z, 1 track, 2 force up, 3 force down |
| icode_i | input | 3 | Pump current-step code |
| up_o | output | 1 | Pump-up command |
| dn_o | output | 1 | Pump-down command |
| oe_o | output | 1 | Pump output enable (low in high-Z mode) |
| icode_o | output | 3 | Registered current-step code |

## Verification
The detector is driven with four edge patterns:
- A reference edge ahead of the feedback edge, which confirms that the up command leads.
- A feedback edge ahead of the reference edge, which confirms that the down command leads.
- Coincident edges, which must give only the stretched overlap.
- A reference running faster than the feedback, with a second reference edge landing before the feedback edge. This shows whether the extra edge is swallowed rather than queued.

The patterns run at several stretch codes, which separates a stretch counted as code+1 cycles from one counted off by one. Mode sequences first store an edge, then switch away and back, to show whether a stale latch survives a mode change.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PM_HIZ     = 2'd0,
        PM_TRACK   = 2'd1,
        PM_PUSH_UP = 2'd2,
        PM_PUSH_DN = 2'd3
    } pump_mode_e;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer #(
    parameter int ABL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             flush_i,
    input  logic [ABL_W-1:0] lim_i,
    output logic             expire_o
);
    logic [ABL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = run_i && (cnt_q == lim_i);
        if (flush_i || !run_i || expire_o) cnt_d = '0;
        else                               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pfd_abl_top.sv
module pfd_abl_top
    import pfd_pkg::*;
#(
    parameter int ABL_W   = 2,
    parameter int ICODE_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               ref_i,
    input  logic               fb_i,
    input  logic [ABL_W-1:0]   abl_sel_i,
    input  logic [1:0]         mode_i,
    input  logic [ICODE_W-1:0] icode_i,
    output logic               up_o,
    output logic               dn_o,
    output logic               oe_o,
    output logic [ICODE_W-1:0] icode_o
);
    localparam int NCH   = 2;
    localparam int OVL_W = ABL_W + 1;
    localparam int OVL_MAX = 1 << ABL_W;

    typedef struct packed {
        logic               up;
        logic               dn;
        pump_mode_e         mode;
        logic [ICODE_W-1:0] icode;
    } pfd_state_t;

    pfd_state_t s_d, s_q;
    logic [NCH-1:0] pulse_in;
    logic [NCH-1:0] rise;
    logic           mode_chg;
    logic           abl_expire;

    assign pulse_in = {fb_i, ref_i};

    // one edge detector per compared input
    for (genvar ch = 0; ch < NCH; ch++) begin : g_edge
        pfd_edge_det u_edge (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .sig_i  (pulse_in[ch]),
            .rise_o (rise[ch])
        );
    end

    assign mode_chg = (mode_i != s_q.mode);

    pfd_abl_timer #(.ABL_W(ABL_W)) u_timer (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .run_i    (s_q.up & s_q.dn),
        .flush_i  (mode_chg),
        .lim_i    (abl_sel_i),
        .expire_o (abl_expire)
    );

    always_comb begin
        s_d       = s_q;
        s_d.icode = icode_i;
        s_d.mode  = pump_mode_e'(mode_i);
        if (mode_chg || s_q.mode != PM_TRACK || abl_expire) begin
            s_d.up = 1'b0;
            s_d.dn = 1'b0;
        end else begin
            s_d.up = s_q.up | rise[0];
            s_d.dn = s_q.dn | rise[1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.up    <= 1'b0;
            s_q.dn    <= 1'b0;
            s_q.mode  <= PM_HIZ;
            s_q.icode <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        up_o    = ((s_q.mode == PM_TRACK) & s_q.up) | (s_q.mode == PM_PUSH_UP);
        dn_o    = ((s_q.mode == PM_TRACK) & s_q.dn) | (s_q.mode == PM_PUSH_DN);
        oe_o    = (s_q.mode != PM_HIZ);
        icode_o = s_q.icode;
    end

    // run length of the overlap, used only by the checks below
    logic [OVL_W-1:0] ovl_d, ovl_q;

    always_comb begin
        if (up_o && dn_o && ovl_q != OVL_W'(OVL_MAX)) ovl_d = ovl_q + 1'b1;
        else if (up_o && dn_o)                        ovl_d = ovl_q;
        else                                          ovl_d = '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ovl_q <= '0;
        else       ovl_q <= ovl_d;
    end

    a_r3_abl_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        (up_o && dn_o) |-> (ovl_q < OVL_W'(OVL_MAX)));

    a_r3_clear_together: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(up_o) && $stable(s_q.mode)) |-> $fell(dn_o));

    a_r5_hiz: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'd0) |=> (!oe_o && !up_o && !dn_o));

    a_r6_force_up: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'd2) |=> (oe_o && up_o && !dn_o));

    a_r6_force_dn: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'd3) |=> (oe_o && dn_o && !up_o));

    a_r8_icode: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (icode_o == $past(icode_i)));
endmodule

// File: tb/pfd_abl_top_tb_top.sv
module pfd_abl_top_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       up;
        logic       dn;
        logic       oe;
        logic [2:0] ic;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_s = 1'b0;
    logic       fb_s = 1'b0;
    logic [1:0] abl = 2'd0;
    logic [1:0] mode = 2'd1;
    logic [2:0] ic = 3'd0;
    logic       up, dn, oe;
    logic [2:0] ic_o;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_abl_top dut_i (
        .clk_i(clk), .rst_i(rst), .ref_i(ref_s), .fb_i(fb_s),
        .abl_sel_i(abl), .mode_i(mode), .icode_i(ic),
        .up_o(up), .dn_o(dn), .oe_o(oe), .icode_o(ic_o)
    );

    // driver: apply inputs at the falling edge, queue the result expected after the next rising edge
    task automatic step(input logic r, input logic rf, input logic ff, input logic [1:0] m,
                        input logic [1:0] a, input logic [2:0] c,
                        input logic eu, input logic ed, input logic eo, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; ref_s = rf; fb_s = ff; mode = m; abl = a; ic = c;
        e.up = eu; e.dn = ed; e.oe = eo; e.ic = r ? 3'd0 : c; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (up !== e.up || dn !== e.dn || oe !== e.oe || ic_o !== e.ic) begin
                    n_fail++;
                    $display("FAIL %s: got up=%b dn=%b oe=%b ic=%0d, expected up=%b dn=%b oe=%b ic=%0d",
                             e.tag, up, dn, oe, ic_o, e.up, e.dn, e.oe, e.ic);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) step(1, 0, 0, 2'd1, 2'd0, 3'd5, 0, 0, 0, "R1 reset");
        step(0, 0, 0, 2'd1, 2'd0, 3'd5, 0, 0, 1, "R5 enter track");
        // R2/R3 reference leads, stretch 1
        step(0, 1, 0, 2'd1, 2'd0, 3'd5, 1, 0, 1, "R2 ref lead");
        step(0, 1, 0, 2'd1, 2'd0, 3'd6, 1, 0, 1, "R2 up held R8");
        step(0, 0, 1, 2'd1, 2'd0, 3'd6, 1, 1, 1, "R3 overlap c0");
        step(0, 0, 1, 2'd1, 2'd0, 3'd6, 0, 0, 1, "R3 clear c0");
        step(0, 0, 0, 2'd1, 2'd3, 3'd2, 0, 0, 1, "R3 idle");
        // feedback leads, stretch 4
        step(0, 0, 1, 2'd1, 2'd3, 3'd2, 0, 1, 1, "R2 fb lead");
        step(0, 0, 1, 2'd1, 2'd3, 3'd2, 0, 1, 1, "R2 dn held");
        step(0, 1, 0, 2'd1, 2'd3, 3'd2, 1, 1, 1, "R3 overlap c3 1");
        step(0, 1, 0, 2'd1, 2'd3, 3'd2, 1, 1, 1, "R3 overlap c3 2");
        step(0, 1, 0, 2'd1, 2'd3, 3'd2, 1, 1, 1, "R3 overlap c3 3");
        step(0, 1, 0, 2'd1, 2'd3, 3'd2, 1, 1, 1, "R3 overlap c3 4");
        step(0, 1, 0, 2'd1, 2'd3, 3'd2, 0, 0, 1, "R3 clear c3");
        step(0, 0, 0, 2'd1, 2'd1, 3'd2, 0, 0, 1, "R3 idle");
        // coincident edges, stretch 2
        step(0, 1, 1, 2'd1, 2'd1, 3'd7, 1, 1, 1, "R3 coincident 1");
        step(0, 0, 0, 2'd1, 2'd1, 3'd7, 1, 1, 1, "R3 coincident 2");
        step(0, 0, 0, 2'd1, 2'd1, 3'd7, 0, 0, 1, "R3 coincident clear");
        // faster reference: second edge ignored
        step(0, 1, 0, 2'd1, 2'd0, 3'd1, 1, 0, 1, "R4 first ref");
        step(0, 0, 0, 2'd1, 2'd0, 3'd1, 1, 0, 1, "R4 wait");
        step(0, 1, 0, 2'd1, 2'd0, 3'd1, 1, 0, 1, "R4 second ref");
        step(0, 0, 0, 2'd1, 2'd0, 3'd1, 1, 0, 1, "R4 wait");
        step(0, 0, 1, 2'd1, 2'd0, 3'd1, 1, 1, 1, "R4 fb arrives");
        step(0, 0, 0, 2'd1, 2'd0, 3'd1, 0, 0, 1, "R4 cleared");
        step(0, 0, 0, 2'd1, 2'd0, 3'd1, 0, 0, 1, "R4 no rearm");
        // edge during overlap ignored, stretch 2
        step(0, 1, 0, 2'd1, 2'd1, 3'd3, 1, 0, 1, "R4 ref");
        step(0, 0, 1, 2'd1, 2'd1, 3'd3, 1, 1, 1, "R4 overlap 1");
        step(0, 1, 0, 2'd1, 2'd1, 3'd3, 1, 1, 1, "R4 ref in overlap");
        step(0, 0, 0, 2'd1, 2'd1, 3'd3, 0, 0, 1, "R4 overlap clear");
        step(0, 0, 0, 2'd1, 2'd1, 3'd3, 0, 0, 1, "R4 no pending up");
        // modes
        step(0, 0, 0, 2'd2, 2'd0, 3'd4, 1, 0, 1, "R6 force up");
        step(0, 0, 1, 2'd2, 2'd0, 3'd4, 1, 0, 1, "R9 fb in force up");
        step(0, 0, 0, 2'd1, 2'd0, 3'd4, 0, 0, 1, "R9 back to track");
        step(0, 0, 0, 2'd3, 2'd0, 3'd4, 0, 1, 1, "R6 force down");
        step(0, 0, 0, 2'd0, 2'd0, 3'd4, 0, 0, 0, "R5 high-Z");
        step(0, 1, 0, 2'd0, 2'd0, 3'd4, 0, 0, 0, "R9 ref in high-Z");
        step(0, 0, 0, 2'd0, 2'd0, 3'd4, 0, 0, 0, "R5 high-Z held");
        step(0, 0, 0, 2'd1, 2'd0, 3'd4, 0, 0, 1, "R9 no stale");
        step(0, 1, 0, 2'd1, 2'd0, 3'd4, 1, 0, 1, "R7 latch up");
        step(0, 0, 0, 2'd3, 2'd0, 3'd4, 0, 1, 1, "R7 switch away");
        step(0, 0, 0, 2'd1, 2'd0, 3'd4, 0, 0, 1, "R7 latch cleared");
        step(0, 0, 0, 2'd1, 2'd0, 3'd4, 0, 0, 1, "R7 still clear");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule